// File: doc/BRIEF.md
# SPI Master with Select-to-Clock Delay

This block is a memory-mapped serial master for a soft-processor system running from a 50 MHz clock. It owns a single slave-select line and moves 16-bit words in both directions. The most significant bit goes out first. The serial clock runs at a fixed 250 kHz, which is 200 system cycles per period. The link uses mode 0: the clock idles low, the outgoing bit changes on the falling edge, and the incoming bit is sampled on the rising edge.

When a transfer starts from idle, the select line goes low and the block waits a fixed 100 system cycles (2 us) before the serial clock begins. Software sees six word-spaced registers: receive data, transmit data, flags, interrupt enables, select enable and a match word. A transmit write made while a word is shifting waits in a one-word holding buffer. It follows the current word with no gap, and the select line stays low across both words. When a sent or received word equals the match word, a flag is set. The interrupt output is the registered OR of the enabled flags.

Top module: `spi_sel_master`

## Requirements
- R1: After reset, and whenever no transfer is in progress, ss_n is 1 and sclk is 0. After reset irq is 0 and the flag register reads 0x05.
- R2: Each word is driven on mosi most significant bit first. mosi only changes while sclk is low, so it is stable for the whole high phase.
- R3: Inside a transfer, each sclk phase lasts exactly 100 system cycles: a rising edge comes 100 cycles after the previous falling edge.
- R4: When a transfer starts from idle, the first rising sclk edge comes exactly 200 cycles after ss_n falls. That is 100 cycles (2 us) of select lead time plus one low half period.
- R5: A completed word places the 16 bits sampled on miso, first sample in bit 15, into the receive register. The receive register is word index 0, byte offset 0x00.
- R6: Writing the transmit register (word index 1) starts a transfer if the block is idle. While a word is shifting, the write is held in a one-word buffer and that word follows back-to-back under one continuous ss_n low period. ss_n rises after the last word once the buffer is empty.
- R7: The flag register is word index 2. Its bits are: bit0 transmit buffer free, bit1 receive word ready, bit2 shifter and buffer empty, bit3 receive overrun, bit4 match seen. Reading the receive register clears bit1. Completing a word while bit1 is still set sets bit3. Any write to the flag register clears bits 3 and 4.
- R8: Bit4 is set when a completed word, either the one sent or the one received, equals the match register (word index 6).
- R9: irq goes to 1 when a flag bit is set and the same bit is set in the enable register (word index 3). irq returns to 0 once no enabled flag remains.
- R10: The select-enable register (word index 5, bit0, reset value 1) is 1 for normal operation. When it is 0, transfers still shift data but ss_n stays 1.
- R11: A transmit write made while the holding buffer is full (flag bit0 = 0) is ignored: no word is sent for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 50 MHz |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the back-to-back path: a second word is accepted into the holding buffer and then a third write arrives while the buffer is still full. In the same window the unread first receive word must turn into an overrun. The stimulus issues three transmit writes in consecutive bus cycles right after a start from idle. A scoreboard then confirms that exactly two words leave under a single select assertion. A second hard case is a match detected only on the receive side; the slave model returns the match word while the master sends something else.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2
  } xfer_state_t;

  localparam int REG_RX   = 0;
  localparam int REG_TX   = 1;
  localparam int REG_FLAG = 2;
  localparam int REG_EN   = 3;
  localparam int REG_SEL  = 5;
  localparam int REG_EOP  = 6;

  localparam int FLAG_W     = 5;
  localparam int F_TX_FREE  = 0;
  localparam int F_RX_READY = 1;
  localparam int F_EMPTY    = 2;
  localparam int F_OVERRUN  = 3;
  localparam int F_MATCH    = 4;
endpackage

// File: rtl/spi_sel_shifter.sv
module spi_sel_shifter
  import spi_sel_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int HALF_DIV  = 100,
  parameter int SEL_DELAY = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_valid,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              miso,
  output logic              buf_take,
  output logic              sclk,
  output logic              mosi,
  output logic              active,
  output logic              word_done,
  output logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] tx_word
);
  localparam int CNT_MAX = (HALF_DIV > SEL_DELAY) ? HALF_DIV : SEL_DELAY;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(DATA_W);

  xfer_state_t       state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q, rxs_q, txw_q;
  logic              sclk_q;
  logic              half_end, last_edge;

  assign half_end  = (cnt_q == CW'(HALF_DIV - 1));
  assign last_edge = (state_q == ST_SHIFT) && half_end && sclk_q &&
                     (bit_q == BW'(DATA_W - 1));
  assign buf_take  = buf_valid && ((state_q == ST_IDLE) || last_edge);

  assign sclk   = sclk_q;
  assign mosi   = sh_q[DATA_W-1];
  assign active = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      rxs_q     <= '0;
      txw_q     <= '0;
      sclk_q    <= 1'b0;
      word_done <= 1'b0;
      rx_word   <= '0;
      tx_word   <= '0;
    end else begin
      word_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (buf_take) begin
            sh_q    <= buf_data;
            txw_q   <= buf_data;
            bit_q   <= '0;
            cnt_q   <= '0;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (cnt_q == CW'(SEL_DELAY - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_SHIFT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (half_end) begin
            cnt_q <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rxs_q  <= {rxs_q[DATA_W-2:0], miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == BW'(DATA_W - 1)) begin
                word_done <= 1'b1;
                rx_word   <= rxs_q;
                tx_word   <= txw_q;
                if (buf_take) begin
                  sh_q  <= buf_data;
                  txw_q <= buf_data;
                  bit_q <= '0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_sel_regs.sv
module spi_sel_regs
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              buf_take,
  input  logic              active,
  input  logic              word_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic [DATA_W-1:0] tx_word,
  output logic              buf_valid,
  output logic [DATA_W-1:0] buf_data,
  output logic              sel_en,
  output logic              irq
);
  logic [DATA_W-1:0] rx_q, eop_q;
  logic [FLAG_W-1:0] en_q, flags;
  logic              rx_ready_q, ovr_q, match_q;
  logic              rd_rx, wr_flag;

  assign rd_rx   = bus_rd && (bus_addr == AW'(REG_RX));
  assign wr_flag = bus_wr && (bus_addr == AW'(REG_FLAG));

  always_comb begin
    flags             = '0;
    flags[F_TX_FREE]  = !buf_valid;
    flags[F_RX_READY] = rx_ready_q;
    flags[F_EMPTY]    = !buf_valid && !active;
    flags[F_OVERRUN]  = ovr_q;
    flags[F_MATCH]    = match_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_valid  <= 1'b0;
      buf_data   <= '0;
      rx_q       <= '0;
      eop_q      <= '0;
      en_q       <= '0;
      sel_en     <= 1'b1;
      rx_ready_q <= 1'b0;
      ovr_q      <= 1'b0;
      match_q    <= 1'b0;
      bus_rdata  <= '0;
      irq        <= 1'b0;
    end else begin
      if (buf_take) buf_valid <= 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          AW'(REG_TX):  if (!buf_valid) begin
                          buf_valid <= 1'b1;
                          buf_data  <= bus_wdata;
                        end
          AW'(REG_EN):  en_q   <= bus_wdata[FLAG_W-1:0];
          AW'(REG_SEL): sel_en <= bus_wdata[0];
          AW'(REG_EOP): eop_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (wr_flag) begin
        ovr_q   <= 1'b0;
        match_q <= 1'b0;
      end
      if (rd_rx) rx_ready_q <= 1'b0;
      if (word_done) begin
        rx_q       <= rx_word;
        rx_ready_q <= 1'b1;
        if (rx_ready_q && !rd_rx) ovr_q <= 1'b1;
        if ((rx_word == eop_q) || (tx_word == eop_q)) match_q <= 1'b1;
      end
      if (bus_rd) begin
        case (bus_addr)
          AW'(REG_RX):   bus_rdata <= rx_q;
          AW'(REG_FLAG): bus_rdata <= DATA_W'(flags);
          AW'(REG_EN):   bus_rdata <= DATA_W'(en_q);
          AW'(REG_SEL):  bus_rdata <= DATA_W'(sel_en);
          AW'(REG_EOP):  bus_rdata <= eop_q;
          default:       bus_rdata <= '0;
        endcase
      end
      irq <= |(flags & en_q);
    end
  end
endmodule

// File: rtl/spi_sel_master.sv
module spi_sel_master #(
  parameter int DATA_W    = 16,
  parameter int HALF_DIV  = 100,
  parameter int SEL_DELAY = 100,
  parameter int AW        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n,
  output logic              irq
);
  logic              buf_valid, buf_take, xfer_active, word_done, sel_en;
  logic [DATA_W-1:0] buf_data, rx_word, tx_word;

  spi_sel_regs #(.DATA_W(DATA_W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .buf_take(buf_take), .active(xfer_active), .word_done(word_done),
    .rx_word(rx_word), .tx_word(tx_word), .buf_valid(buf_valid),
    .buf_data(buf_data), .sel_en(sel_en), .irq(irq)
  );

  spi_sel_shifter #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .SEL_DELAY(SEL_DELAY)) u_shift (
    .clk(clk), .rst(rst), .buf_valid(buf_valid), .buf_data(buf_data),
    .miso(miso), .buf_take(buf_take), .sclk(sclk), .mosi(mosi),
    .active(xfer_active), .word_done(word_done), .rx_word(rx_word),
    .tx_word(tx_word)
  );

  assign ss_n = !(xfer_active && sel_en);
endmodule

// File: rtl/spi_sel_master_chk.sv
module spi_sel_master_chk #(
  parameter int HALF_DIV  = 100,
  parameter int SEL_DELAY = 100
) (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic mosi,
  input logic ss_n,
  input logic active
);
  logic [15:0] since_edge, since_start;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      since_edge  <= '0;
      since_start <= '0;
    end else begin
      since_edge  <= (sclk != $past(sclk)) ? 16'd1 :
                     ((since_edge == 16'hFFFF) ? since_edge : since_edge + 16'd1);
      since_start <= (since_start == 16'hFFFF) ? since_start : since_start + 16'd1;
    end
  end

  // R1: idle lines
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
    !active |-> (ss_n && !sclk));

  // R2: mosi held through the high phase
  assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R3: no sclk phase shorter than the half period
  assert_half_period_R3: assert property (@(posedge clk) disable iff (rst)
    (active && (sclk != $past(sclk)) && (since_edge != 16'd0)) |->
      (since_edge >= 16'(HALF_DIV - 1)));

  // R4: select lead time before the first edge
  assert_lead_time_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> (since_start >= 16'(SEL_DELAY)));
endmodule

bind spi_sel_master spi_sel_master_chk #(.HALF_DIV(HALF_DIV), .SEL_DELAY(SEL_DELAY)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .active(xfer_active)
);

// File: tb/test_spi_sel_master.sv
module test_spi_sel_master;
  localparam int CLK_PERIOD = 20;
  localparam int HALF = 100;
  localparam int LEAD = 200;

  logic        clk = 0, rst = 1, bus_wr = 0, bus_rd = 0, miso = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata, rd;
  logic        sclk, mosi, ss_n, irq;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] exp_q[$];
  logic [15:0] slave_w[8] = '{16'h3C5A, 16'h5555, 16'hAAAA, 16'h0102,
                              16'h00F0, 16'h4242, 16'h9999, 16'h0000};

  spi_sel_master i_spi_sel_master (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .miso(miso), .sclk(sclk),
    .mosi(mosi), .ss_n(ss_n), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic send(input logic [15:0] d);
    exp_q.push_back(d);
    bus_write(3'd1, d);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    s = 0;
    while (!s[2]) begin
      repeat (20) @(negedge clk);
      bus_read(3'd2, s);
    end
    repeat (4) @(negedge clk);
  endtask

  // monitor: scoreboard on mosi, timing, slave model on miso
  logic sclk_p = 0, ssn_p = 1, first_pend = 0;
  int last_fall = 0, ss_fall_cyc = 0, mon_n = 0, fall_n = 0, sidx = 0, ss_falls = 0;
  logic [15:0] mon_w = 0;

  initial miso = slave_w[0][15];

  always @(negedge clk) begin
    if (!rst) begin
      if (ssn_p && !ss_n) begin ss_falls++; ss_fall_cyc = cyc; first_pend = 1; end
      if (sclk && !sclk_p) begin
        if (first_pend) begin
          check(cyc - ss_fall_cyc == LEAD, "R4 select lead", cyc - ss_fall_cyc, LEAD);
          first_pend = 0;
        end else if (!ss_n) begin
          check(cyc - last_fall == HALF, "R3 half period", cyc - last_fall, HALF);
        end
        mon_w = {mon_w[14:0], mosi};
        mon_n++;
        if (mon_n == 16) begin
          mon_n = 0;
          if (exp_q.size() == 0) check(0, "R11 unexpected word", mon_w, 0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(mon_w == e, "R2 mosi word", mon_w, e);
          end
        end
      end
      if (!sclk && sclk_p) begin
        last_fall = cyc;
        fall_n++;
        if (fall_n == 16) begin fall_n = 0; sidx++; end
        miso = slave_w[sidx % 8][4'(15 - fall_n)];
      end
      sclk_p = sclk; ssn_p = ss_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(ss_n == 1 && sclk == 0, "R1 idle lines", {ss_n, sclk}, 2'b10);
    check(irq == 0, "R1 irq", irq, 0);
    bus_read(3'd2, rd);
    check(rd == 16'h0005, "R1 flags", rd, 16'h0005);

    // R2/R5 single word
    send(16'hA5C3);
    wait_idle();
    bus_read(3'd2, rd);
    check(rd == 16'h0007, "R7 rx ready", rd, 16'h0007);
    bus_read(3'd0, rd);
    check(rd == 16'h3C5A, "R5 rx word", rd, 16'h3C5A);
    bus_read(3'd2, rd);
    check(rd == 16'h0005, "R7 rx ready cleared", rd, 16'h0005);

    // R6/R11 back-to-back with a dropped third write
    f0 = ss_falls;
    send(16'h1234);
    send(16'h8001);
    bus_write(3'd1, 16'hFFFF);
    bus_read(3'd2, rd);
    check(rd[0] == 0, "R11 buffer full", rd[0], 0);
    wait_idle();
    check(ss_falls - f0 == 1, "R6 single select", ss_falls - f0, 1);
    check(exp_q.size() == 0, "R11 no extra word", exp_q.size(), 0);
    bus_read(3'd2, rd);
    check(rd == 16'h000F, "R7 overrun", rd, 16'h000F);
    bus_read(3'd0, rd);
    check(rd == 16'hAAAA, "R5 last rx word", rd, 16'hAAAA);
    bus_write(3'd2, 16'h0000);
    bus_read(3'd2, rd);
    check(rd == 16'h0005, "R7 flag clear", rd, 16'h0005);

    // R8 match on sent word, then on received word
    bus_write(3'd6, 16'h00F0);
    send(16'h00F0);
    wait_idle();
    bus_read(3'd0, rd);
    bus_read(3'd2, rd);
    check(rd == 16'h0015, "R8 match tx", rd, 16'h0015);
    bus_write(3'd2, 16'h0000);
    send(16'h0304);
    wait_idle();
    bus_read(3'd0, rd);
    check(rd == 16'h00F0, "R5 rx word", rd, 16'h00F0);
    bus_read(3'd2, rd);
    check(rd == 16'h0015, "R8 match rx", rd, 16'h0015);
    bus_write(3'd2, 16'h0000);

    // R9 interrupt
    bus_write(3'd3, 16'h0002);
    check(irq == 0, "R9 irq masked idle", irq, 0);
    send(16'h7E81);
    wait_idle();
    check(irq == 1, "R9 irq rx ready", irq, 1);
    bus_read(3'd0, rd);
    repeat (3) @(negedge clk);
    check(irq == 0, "R9 irq after read", irq, 0);
    bus_write(3'd3, 16'h0004);
    repeat (2) @(negedge clk);
    check(irq == 1, "R9 irq empty", irq, 1);
    bus_write(3'd3, 16'h0000);
    repeat (2) @(negedge clk);
    check(irq == 0, "R9 irq disabled", irq, 0);

    // R10 select disabled
    bus_write(3'd5, 16'h0000);
    f0 = ss_falls;
    send(16'h0F0F);
    repeat (300) @(negedge clk);
    check(ss_n == 1, "R10 ss held", ss_n, 1);
    wait_idle();
    check(ss_falls == f0, "R10 no select", ss_falls - f0, 0);
    bus_read(3'd0, rd);
    check(rd == 16'h9999, "R10 rx still shifts", rd, 16'h9999);
    bus_read(3'd5, rd);
    check(rd == 16'h0000, "R10 select reg", rd, 0);
    bus_write(3'd5, 16'h0001);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule